// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a serial-bus slave controller and a byte-wide nonvolatile array. After the controller has decoded a write command and its memory address, it loads that address into the block, then hands over each data byte as it arrives. The block keeps the bytes in a one-page holding buffer and marks every byte lane that has been filled. The page is 16 bytes by default. Inside the page the offset advances and wraps around, so more than a page's worth of data overwrites the earliest bytes.

When the controller reports a stop condition, the block commits the page. The commit is modelled as a timed interval of a programmable number of clock cycles. While that interval runs, the block raises a busy flag and ignores every strobe. In the first cycles of the interval it sends the marked bytes, and only those, to the array write port. The controller answers address polls with a not-acknowledge while busy is high. A write-protect pin, sampled at the stop, locks the upper half of the address space. A locked page, or a stop with no data, is dropped without a busy interval.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, busy_o is low and mem_we_o is low, and they stay low until a committed stop.
- R2: A load_i pulse takes the page number from load_addr_i[ADDR_W-1:4] and the starting offset from load_addr_i[3:0]. Each byte_i pulse stores byte_data_i at the current offset, then increments only the offset, modulo 16.
- R3: Past the last offset the offset wraps to 0 in the same page, and a later byte replaces an earlier byte held at the same offset.
- R4: Only offsets that received a byte since the last load are written. Every other address of the array receives no write.
- R5: A committed stop raises busy_o in the clock after the stop_i cycle, and busy_o then stays high for exactly WRITE_CYCLES cycles.
- R6: While busy, each marked byte appears on the write port exactly once, with mem_addr_o = {page, offset}. Bytes appear in ascending offset order, one per cycle, within the first 16 busy cycles.
- R7: Bytes are written only on a stop. A new load before any stop discards the bytes collected so far.
- R8: Let bit ADDR_W-1 of the address select the upper half. If wp_i is high at the stop and the loaded page lies in the upper half, nothing is written and busy stays low. With wp_i low, upper pages are written, and lower pages are written whatever the level of wp_i.
- R9: load_i, byte_i and stop_i pulses that arrive while busy_o is high have no effect. The busy length does not change, no write results, and no lane is marked.
- R10: A stop with no byte collected since the last load causes no write and no busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load start address strobe |
| load_addr_i | input | ADDR_W | Start address: page number and offset |
| byte_i | input | 1 | Data byte strobe |
| byte_data_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop condition strobe |
| wp_i | input | 1 | Write-protect pin level |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Commit interval in progress |

## Verification
The checker assumes that the controller never raises more than one of load_i, byte_i and stop_i in the same cycle. It also assumes that a page is a power of two in size and that WRITE_CYCLES is at least the page size. The stimulus drives every strobe as a single-cycle pulse, one at a time, set on the falling edge. That holds even when the bench deliberately pulses strobes during a busy interval to show that they are ignored. The protection checks take wp_i at the accepted stop as the level that governs the whole commit, and the bench changes wp_i only between transactions.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic {
        PH_IDLE,
        PH_BUSY
    } phase_e;

    // Commit interval must cover one scan over the page.
    function automatic int unsigned commit_len(input int unsigned cycles,
                                               input int unsigned page);
        return (cycles < page) ? page : cycles;
    endfunction

endpackage

// File: rtl/pwb_lane_store.sv
module pwb_lane_store
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic [OFF_W-1:0]      load_off_i,
    input  logic                  put_i,
    input  byte_t                 put_data_i,
    input  logic                  clr_i,
    input  logic [OFF_W-1:0]      rd_idx_i,
    output byte_t                 rd_data_o,
    output logic [PAGE_BYTES-1:0] mask_o
);

    logic [OFF_W-1:0] off_q;
    byte_t            lane_q [PAGE_BYTES];

    // Offset wraps naturally: only the in-page bits exist.
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else if (load_i) begin
            off_q <= load_off_i;
        end else if (put_i) begin
            off_q <= off_q + 1'b1;
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (put_i && (off_q == OFF_W'(i))) begin
                lane_q[i] <= put_data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                mask_o[i] <= 1'b0;
            end else if (put_i && (off_q == OFF_W'(i))) begin
                mask_o[i] <= 1'b1;
            end
        end
    end

    assign rd_data_o = lane_q[rd_idx_i];

endmodule

// File: rtl/pwb_commit_timer.sv
module pwb_commit_timer
    import pwb_pkg::*;
#(
    parameter int CYC        = 1000,
    parameter int PAGE_BYTES = 16,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    output logic             busy_o,
    output logic [OFF_W-1:0] scan_o,
    output logic             scan_live_o,
    output logic             done_o
);

    localparam int                CNT_W  = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0]  LAST   = CNT_W'(CYC - 1);
    localparam logic [OFF_W:0]    PAGE_L = (OFF_W + 1)'(PAGE_BYTES);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [OFF_W:0]   sidx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            sidx_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (go_i) begin
                        phase_q <= PH_BUSY;
                        cnt_q   <= LAST;
                        sidx_q  <= '0;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                    if (sidx_q < PAGE_L) begin
                        sidx_q <= sidx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy_o      = (phase_q == PH_BUSY);
    assign scan_o      = sidx_q[OFF_W-1:0];
    assign scan_live_o = busy_o && (sidx_q < PAGE_L);
    assign done_o      = busy_o && (cnt_q == '0);

endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              byte_i,
    input  logic [7:0]        byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o,
    output logic              busy_o
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int CYC   = int'(commit_len(WRITE_CYCLES, PAGE_BYTES));

    logic [PG_W-1:0]       page_q;
    logic [PAGE_BYTES-1:0] mask;
    logic [OFF_W-1:0]      scan;
    logic                  scan_live;
    logic                  done;
    byte_t                 rd_data;

    logic accept, ld, put, stp, locked, go, clr;

    assign accept = !busy_o;
    assign ld     = load_i && accept;
    assign put    = byte_i && accept;
    assign stp    = stop_i && accept;
    assign locked = wp_i && page_q[PG_W-1];
    assign go     = stp && (|mask) && !locked;
    assign clr    = ld || (stp && !go) || done;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (ld) begin
            page_q <= load_addr_i[ADDR_W-1:OFF_W];
        end
    end

    pwb_lane_store #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ld),
        .load_off_i (load_addr_i[OFF_W-1:0]),
        .put_i      (put),
        .put_data_i (byte_data_i),
        .clr_i      (clr),
        .rd_idx_i   (scan),
        .rd_data_o  (rd_data),
        .mask_o     (mask)
    );

    pwb_commit_timer #(
        .CYC        (CYC),
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .go_i        (go),
        .busy_o      (busy_o),
        .scan_o      (scan),
        .scan_live_o (scan_live),
        .done_o      (done)
    );

    assign mem_we_o   = scan_live && mask[scan];
    assign mem_addr_o = {page_q, scan};
    assign mem_data_o = rd_data;

endmodule

// File: rtl/pwb_page_writer_chk.sv
module pwb_page_writer_chk
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 50000
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic              byte_i,
    input logic              stop_i,
    input logic              wp_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              busy_o
);

    localparam int          OFF_W = $clog2(PAGE_BYTES);
    localparam int unsigned CYC   = commit_len(WRITE_CYCLES, PAGE_BYTES);

    int unsigned run_q;
    int unsigned wcnt_q;
    logic        wp_lat_q;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) run_q <= 0;
        else                run_q <= run_q + 1;
    end

    always_ff @(posedge clk) begin
        if (rst || !busy_o) wcnt_q <= 0;
        else if (mem_we_o)  wcnt_q <= wcnt_q + 1;
    end

    always_ff @(posedge clk) begin
        if (rst)                  wp_lat_q <= 1'b0;
        else if (stop_i && !busy_o) wp_lat_q <= wp_i;
    end

    // Input contract (R1 context): strobes never overlap.
    a_r1_strobe_contract: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_i, byte_i, stop_i}));

    a_r5_rise_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));

    a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == CYC));

    a_r6_write_inside_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

    a_r6_page_bound: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (wcnt_q < PAGE_BYTES));

    a_r8_upper_locked: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> !(wp_lat_q && mem_addr_o[ADDR_W-1]));

    a_r9_page_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFF_W]));

endmodule

bind pwb_page_writer pwb_page_writer_chk #(
    .ADDR_W       (ADDR_W),
    .PAGE_BYTES   (PAGE_BYTES),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .byte_i     (byte_i),
    .stop_i     (stop_i),
    .wp_i       (wp_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o)
);

// File: tb/pwb_page_writer_test.sv
module pwb_page_writer_test;

    localparam int AW  = 11;
    localparam int PG  = 16;
    localparam int CYC = 40;
    localparam int NA  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic          byte_i = 1'b0;
    logic [7:0]    byte_data_i = '0;
    logic          stop_i = 1'b0;
    logic          wp_i = 1'b0;
    logic          mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_data_o;
    logic          busy_o;

    always #2 clk = ~clk;

    pwb_page_writer #(.ADDR_W(AW), .PAGE_BYTES(PG), .WRITE_CYCLES(CYC)) uut (
        .clk(clk), .rst(rst), .load_i(load_i), .load_addr_i(load_addr_i),
        .byte_i(byte_i), .byte_data_i(byte_data_i), .stop_i(stop_i),
        .wp_i(wp_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o), .busy_o(busy_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    logic [7:0] dut_mem [NA];
    logic [7:0] exp_mem [NA];
    int         wr_cnt = 0;
    int         order_bad = 0;
    logic [AW-1:0] last_addr = '0;

    int         m_page = 0;
    int         m_off = 0;
    logic [7:0] m_lane [PG];
    logic [PG-1:0] m_mask = '0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mem_we_o) begin
            if (wr_cnt != 0 && mem_addr_o <= last_addr) order_bad++;
            last_addr = mem_addr_o;
            dut_mem[mem_addr_o] = mem_data_o;
            wr_cnt++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    task automatic clear_strobes();
        load_i = 1'b0; byte_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic b_load(input int a);
        m_page = a >> 4;
        m_off  = a & 15;
        m_mask = '0;
        load_i = 1'b1; load_addr_i = AW'(a);
        @(negedge clk); clear_strobes();
    endtask

    task automatic b_byte(input logic [7:0] d);
        m_lane[m_off] = d;
        m_mask[m_off] = 1'b1;
        m_off = (m_off + 1) % PG;
        byte_i = 1'b1; byte_data_i = d;
        @(negedge clk); clear_strobes();
    endtask

    function automatic int mem_mismatch();
        int n = 0;
        for (int i = 0; i < NA; i++) if (dut_mem[i] !== exp_mem[i]) n++;
        return n;
    endfunction

    // Issue a stop and check the whole commit. inj: pulse strobes while busy.
    task automatic b_stop(input logic wp, input bit inj);
        bit commit;
        int ewr;
        int len;
        commit = (m_mask != '0) && !(wp && (m_page >= (NA / PG / 2)));
        ewr = $countones(m_mask);
        if (commit)
            for (int k = 0; k < PG; k++)
                if (m_mask[k]) exp_mem[m_page * PG + k] = m_lane[k];
        m_mask = '0;
        wr_cnt = 0; order_bad = 0;
        wp_i = wp; stop_i = 1'b1;
        @(negedge clk); clear_strobes();
        chk(commit ? "R5 busy rise" : "R8/R10 no busy", int'(busy_o), int'(commit));
        if (commit) begin
            len = 1;
            while (1) begin
                if (inj) begin
                    if (len == 2) begin load_i = 1'b1; load_addr_i = 11'h7F0; end
                    if (len == 3) begin byte_i = 1'b1; byte_data_i = 8'hEE; end
                    if (len == 4) stop_i = 1'b1;
                end
                @(negedge clk); clear_strobes();
                if (!busy_o) break;
                len++;
                if (len > CYC + 10) break;
            end
            chk(inj ? "R9 busy length" : "R5 busy length", len, CYC);
            chk("R6 write order", order_bad, 0);
        end
        chk("R4/R6 write count", wr_cnt, commit ? ewr : 0);
        chk("R2/R3/R4 memory image", mem_mismatch(), 0);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NA; i++) begin
            dut_mem[i] = 8'((i * 5) ^ 8'h5A);
            exp_mem[i] = 8'((i * 5) ^ 8'h5A);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset busy", int'(busy_o), 0);
        chk("R1 reset write", int'(mem_we_o), 0);
        repeat (5) @(negedge clk);
        chk("R1 idle writes", wr_cnt, 0);

        // Sweep start offset and burst length on lower pages (R2, R3, R4).
        for (int off = 0; off < PG; off++) begin
            for (int li = 0; li < 4; li++) begin
                int n;
                int base;
                n = (li == 0) ? 1 : (li == 1) ? 7 : (li == 2) ? 16 : 19;
                base = ((off * 3 + li * 11 + 5) % 64) * PG + off;
                b_load(base);
                for (int k = 0; k < n; k++) b_byte(8'(base * 7 + k * 13 + li));
                b_stop(off[0], 1'b0);
            end
        end

        // R8: upper page locked, then open, then lower page with pin high.
        b_load(12'h4A3); for (int k = 0; k < 5; k++) b_byte(8'(8'hA0 + k));
        b_stop(1'b1, 1'b0);
        b_load(12'h4A3); for (int k = 0; k < 5; k++) b_byte(8'(8'hB0 + k));
        b_stop(1'b0, 1'b0);
        b_load(12'h7FE); for (int k = 0; k < 4; k++) b_byte(8'(8'hC0 + k));
        b_stop(1'b0, 1'b0);
        b_load(12'h123); for (int k = 0; k < 3; k++) b_byte(8'(8'hD0 + k));
        b_stop(1'b1, 1'b0);

        // R7: bytes without a stop are discarded by the next load.
        b_load(12'h210); for (int k = 0; k < 6; k++) b_byte(8'(8'h11 * k));
        b_load(12'h31C); for (int k = 0; k < 3; k++) b_byte(8'(8'h70 + k));
        b_stop(1'b0, 1'b0);

        // R10: stop with nothing collected.
        b_load(12'h050);
        b_stop(1'b0, 1'b0);

        // R9: strobes during busy are ignored; a later bare stop marks nothing.
        b_load(12'h0A8); for (int k = 0; k < 9; k++) b_byte(8'(8'h33 + k));
        b_stop(1'b0, 1'b1);
        b_stop(1'b0, 1'b0);

        summary();
    end

endmodule